// File: doc/BRIEF.md
# Profiling Record Packet Writer

This block turns one profiling sample into a record of typed packets and stores that record, one byte at a time, in a linear memory buffer. A sample holds a program-counter address, an operation type, a branch target with condition flags, two 16-bit cycle counts, an event byte and a 64-bit timestamp. The record is written forward from a software-loaded pointer. Every packet starts with a header byte that names its type, so a reader can walk the buffer from the front.

The check against the software-set limit happens before a record starts, and it covers the whole record. If the record does not fit, the sample is consumed and discarded and the interrupt line goes high. The writer then drops every sample it receives until software clears the interrupt. Software normally reloads the pointer at the same time.

The memory port is a request/ready handshake that carries one byte per accepted transfer. The address on that port is the write pointer itself, so software can read back how far the buffer has filled.

Top module: `recPktWriter`

## Requirements
- R1: After reset, `wrAddr` is 0, `bufIrq` is 0, `wrReq` is 0 and `smpReady` is 1.
- R2: With the timestamp option off, a record is 29 bytes. It holds, in this order: header 0x01 and the PC (8 bytes), header 0x02 and the type (1 byte), header 0x03 and the issue count (2 bytes), header 0x01 and the target (8 bytes), header 0x03 and the completion count (2 bytes), header 0x04 and the events (1 byte), then the end byte 0x00. All payloads are little-endian.
- R3: When `cfgTsEnable` is 1 at the moment a sample is accepted, header 0x05 and the 8-byte timestamp come just before the end byte, which makes the record 38 bytes.
- R4: Each byte is written at the current pointer in one `wrReq`&&`wrReady` transfer. While `wrReady` is low, `wrReq`, `wrAddr` and `wrData` stay stable.
- R5: The pointer rises by exactly one for every byte transferred, so after a record it has advanced by the record length.
- R6: A sample is written only if pointer + record length <= `cfgLimit`. A record that ends exactly at the limit is written.
- R7: A sample whose record does not fit is consumed. Nothing is written for it, the pointer is unchanged and `bufIrq` goes to 1.
- R8: While `bufIrq` is 1, every sample is consumed and dropped without any write, even one that would fit.
- R9: A pulse on `irqClear` returns `bufIrq` to 0. If a new overflow happens in the same cycle, setting wins.
- R10: `ptrLoad` loads `ptrLoadVal` into the pointer when no record is in progress, and it blocks sample acceptance in that cycle. While a record is being written, `ptrLoad` has no effect.
- R11: The last byte of every record is the end byte 0x00, and the first byte is an address header 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| smpValid | input | 1 | Sample offered |
| smpReady | output | 1 | Sample consumed on this edge when valid |
| smpPc | input | 64 | Operation address |
| smpOpType | input | 8 | Operation type code |
| smpTarget | input | 64 | Branch target with condition flags |
| smpCntIssue | input | 16 | Dispatch-to-issue cycles |
| smpCntDone | input | 16 | Dispatch-to-complete cycles |
| smpEvents | input | 8 | Event flags |
| smpTime | input | 64 | Timestamp value |
| cfgTsEnable | input | 1 | Add timestamp packet to records |
| cfgLimit | input | 32 | Exclusive end address of buffer |
| ptrLoad | input | 1 | Load pointer request |
| ptrLoadVal | input | 32 | Pointer load value |
| irqClear | input | 1 | Clear full interrupt |
| wrReq | output | 1 | Byte write request |
| wrAddr | output | 32 | Write pointer / byte address |
| wrData | output | 8 | Byte to write |
| wrReady | input | 1 | Memory accepts byte |
| bufIrq | output | 1 | Buffer-full interrupt and status |

## Verification
The hardest case to reach from the ports is a pointer-load pulse that arrives in the middle of a record while the memory side is stalling. The bench starts a record with `wrReady` toggling every cycle, waits until a handful of bytes have been written, and then pulses `ptrLoad`. It checks that the record finishes contiguously and that the pointer ends at the original start plus 29. For the overflow and exact-fit cases, the bench steps the pointer and the limit so that the space left is first below the record length and then exactly equal to it. A sentinel fill in the modelled memory shows any stray write.

// File: rtl/recPktPkg.sv
package recPktPkg;
  localparam int HDR_W = 8;
  localparam logic [HDR_W-1:0] HDR_END  = 8'h00;
  localparam logic [HDR_W-1:0] HDR_ADDR = 8'h01;
  localparam logic [HDR_W-1:0] HDR_TYPE = 8'h02;
  localparam logic [HDR_W-1:0] HDR_CNT  = 8'h03;
  localparam logic [HDR_W-1:0] HDR_EVT  = 8'h04;
  localparam logic [HDR_W-1:0] HDR_TS   = 8'h05;

  localparam int ADDR_PAY = 8;
  localparam int CNT_PAY  = 2;
  localparam int BYTE_PAY = 1;
  localparam int REC_PLAIN = 2 * (1 + ADDR_PAY) + 2 * (1 + CNT_PAY) + 2 * (1 + BYTE_PAY) + 1;
  localparam int REC_TS    = REC_PLAIN + 1 + ADDR_PAY;
  localparam int LEN_W     = $clog2(REC_TS + 1);

  typedef struct packed {
    logic capture;
    logic advance;
    logic load;
  } strobe_t;
endpackage

// File: rtl/recPktDatapath.sv
module recPktDatapath
  import recPktPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [63:0]       smpPc,
  input  logic [7:0]        smpOpType,
  input  logic [63:0]       smpTarget,
  input  logic [15:0]       smpCntIssue,
  input  logic [15:0]       smpCntDone,
  input  logic [7:0]        smpEvents,
  input  logic [63:0]       smpTime,
  input  logic              cfgTsEnable,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic [ADDR_W-1:0] ptrLoadVal,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              recFits,
  output logic              lastByte
);
  localparam int BUF_W = REC_TS * 8;

  logic [BUF_W-1:0]  recBuf;
  logic [BUF_W-1:0]  nextRec;
  logic [LEN_W-1:0]  bytesLeft;
  logic [LEN_W-1:0]  newLen;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W:0]   endAddr;

  assign newLen  = cfgTsEnable ? LEN_W'(REC_TS) : LEN_W'(REC_PLAIN);
  assign endAddr = {1'b0, ptrQ} + {{(ADDR_W+1-LEN_W){1'b0}}, newLen};
  assign recFits = endAddr <= {1'b0, cfgLimit};

  always_comb begin
    nextRec = '0;
    nextRec[0*8  +: 8]  = HDR_ADDR;
    nextRec[1*8  +: 64] = smpPc;
    nextRec[9*8  +: 8]  = HDR_TYPE;
    nextRec[10*8 +: 8]  = smpOpType;
    nextRec[11*8 +: 8]  = HDR_CNT;
    nextRec[12*8 +: 16] = smpCntIssue;
    nextRec[14*8 +: 8]  = HDR_ADDR;
    nextRec[15*8 +: 64] = smpTarget;
    nextRec[23*8 +: 8]  = HDR_CNT;
    nextRec[24*8 +: 16] = smpCntDone;
    nextRec[26*8 +: 8]  = HDR_EVT;
    nextRec[27*8 +: 8]  = smpEvents;
    if (cfgTsEnable) begin
      nextRec[28*8 +: 8]  = HDR_TS;
      nextRec[29*8 +: 64] = smpTime;
      nextRec[37*8 +: 8]  = HDR_END;
    end else begin
      nextRec[28*8 +: 8]  = HDR_END;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recBuf    <= '0;
      bytesLeft <= '0;
    end else if (stb.capture) begin
      recBuf    <= nextRec;
      bytesLeft <= newLen;
    end else if (stb.advance) begin
      recBuf    <= recBuf >> 8;
      bytesLeft <= bytesLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptrQ <= '0;
    else if (stb.load)    ptrQ <= ptrLoadVal;
    else if (stb.advance) ptrQ <= ptrQ + 1'b1;
  end

  assign wrData   = recBuf[7:0];
  assign wrAddr   = ptrQ;
  assign lastByte = bytesLeft == LEN_W'(1);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> wrAddr == $past(wrAddr) + 1'b1); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance && !stb.load |=> $stable(wrAddr)); // R7
endmodule

// File: rtl/recPktCtrl.sv
module recPktCtrl
  import recPktPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    smpValid,
  input  logic    wrReady,
  input  logic    recFits,
  input  logic    lastByte,
  input  logic    ptrLoad,
  input  logic    irqClear,
  output logic    smpReady,
  output logic    wrReq,
  output logic    bufIrq,
  output strobe_t stb
);
  typedef enum logic {ST_IDLE, ST_WRITE} state_t;
  state_t stateQ;
  logic   take;
  logic   overflow;

  assign smpReady    = (stateQ == ST_IDLE) && !ptrLoad;
  assign take        = smpValid && smpReady;
  assign overflow    = take && !bufIrq && !recFits;
  assign stb.capture = take && !bufIrq && recFits;
  assign stb.load    = (stateQ == ST_IDLE) && ptrLoad;
  assign stb.advance = (stateQ == ST_WRITE) && wrReady;
  assign wrReq       = stateQ == ST_WRITE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else case (stateQ)
      ST_IDLE:  if (stb.capture) stateQ <= ST_WRITE;
      ST_WRITE: if (wrReady && lastByte) stateQ <= ST_IDLE;
      default:  stateQ <= ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         bufIrq <= 1'b0;
    else if (overflow) bufIrq <= 1'b1;
    else if (irqClear) bufIrq <= 1'b0;
  end

  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    bufIrq |-> !wrReq); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    smpReady |-> !wrReq); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    smpValid && smpReady && !recFits |=> bufIrq); // R7
endmodule

// File: rtl/recPktWriter.sv
module recPktWriter
  import recPktPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smpValid,
  output logic              smpReady,
  input  logic [63:0]       smpPc,
  input  logic [7:0]        smpOpType,
  input  logic [63:0]       smpTarget,
  input  logic [15:0]       smpCntIssue,
  input  logic [15:0]       smpCntDone,
  input  logic [7:0]        smpEvents,
  input  logic [63:0]       smpTime,
  input  logic              cfgTsEnable,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrLoadVal,
  input  logic              irqClear,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  input  logic              wrReady,
  output logic              bufIrq
);
  strobe_t stb;
  logic    recFits;
  logic    lastByte;

  recPktCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .smpValid(smpValid), .wrReady(wrReady),
    .recFits(recFits), .lastByte(lastByte), .ptrLoad(ptrLoad),
    .irqClear(irqClear), .smpReady(smpReady), .wrReq(wrReq),
    .bufIrq(bufIrq), .stb(stb)
  );

  recPktDatapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .smpPc(smpPc), .smpOpType(smpOpType),
    .smpTarget(smpTarget), .smpCntIssue(smpCntIssue), .smpCntDone(smpCntDone),
    .smpEvents(smpEvents), .smpTime(smpTime), .cfgTsEnable(cfgTsEnable),
    .cfgLimit(cfgLimit), .ptrLoadVal(ptrLoadVal), .wrAddr(wrAddr),
    .wrData(wrData), .recFits(recFits), .lastByte(lastByte)
  );

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrReady |=> wrReq && $stable(wrData) && $stable(wrAddr)); // R4
  AST_FIRST_HDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrReq) |-> wrData == HDR_ADDR); // R11
  AST_END_LAST: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && wrReady && lastByte |-> wrData == HDR_END); // R11
endmodule

// File: tb/test_recPktWriter.sv
module test_recPktWriter;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h1000;
  localparam int MEM_SZ = 128;

  logic clk = 0, rstN = 0;
  logic smpValid = 0, smpReady;
  logic [63:0] smpPc = 0, smpTarget = 0, smpTime = 0;
  logic [7:0] smpOpType = 0, smpEvents = 0;
  logic [15:0] smpCntIssue = 0, smpCntDone = 0;
  logic cfgTsEnable = 0, ptrLoad = 0, irqClear = 0;
  logic [31:0] cfgLimit = BASE + 128, ptrLoadVal = 0;
  logic wrReq, wrReady = 1, bufIrq;
  logic [31:0] wrAddr;
  logic [7:0] wrData;
  logic stallMode = 0;

  logic [7:0] mem [0:MEM_SZ-1];
  int writes = 0, compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  recPktWriter i_recPktWriter (
    .clk(clk), .rstN(rstN), .smpValid(smpValid), .smpReady(smpReady),
    .smpPc(smpPc), .smpOpType(smpOpType), .smpTarget(smpTarget),
    .smpCntIssue(smpCntIssue), .smpCntDone(smpCntDone), .smpEvents(smpEvents),
    .smpTime(smpTime), .cfgTsEnable(cfgTsEnable), .cfgLimit(cfgLimit),
    .ptrLoad(ptrLoad), .ptrLoadVal(ptrLoadVal), .irqClear(irqClear),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady),
    .bufIrq(bufIrq)
  );

  always @(posedge clk) if (rstN && wrReq && wrReady) begin
    writes <= writes + 1;
    if (wrAddr >= BASE && wrAddr < BASE + MEM_SZ) mem[wrAddr - BASE] <= wrData;
  end

  always @(negedge clk) wrReady <= stallMode ? ~wrReady : 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int k, input bit ts);
    if (k == 0 || k == 14) return 8'h01;
    if (k >= 1 && k <= 8) return smpPc[(k-1)*8 +: 8];
    if (k == 9) return 8'h02;
    if (k == 10) return smpOpType;
    if (k == 11 || k == 23) return 8'h03;
    if (k == 12 || k == 13) return smpCntIssue[(k-12)*8 +: 8];
    if (k >= 15 && k <= 22) return smpTarget[(k-15)*8 +: 8];
    if (k == 24 || k == 25) return smpCntDone[(k-24)*8 +: 8];
    if (k == 26) return 8'h04;
    if (k == 27) return smpEvents;
    if (ts && k == 28) return 8'h05;
    if (ts && k >= 29 && k <= 36) return smpTime[(k-29)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic setFields(input int seed);
    smpPc       = 64'h1122_3344_5566_7788 + 64'(seed);
    smpOpType   = 8'(8'h40 + seed);
    smpTarget   = 64'hA0B0_C0D0_E0F0_0102 ^ 64'(seed << 8);
    smpCntIssue = 16'(16'h0310 + seed);
    smpCntDone  = 16'(16'h1720 + seed);
    smpEvents   = 8'(8'h81 ^ seed);
    smpTime     = 64'hFEDC_BA98_7654_3210 - 64'(seed);
  endtask

  task automatic sendSample();
    @(negedge clk);
    smpValid = 1;
    while (!smpReady) @(negedge clk);
    @(negedge clk);
    smpValid = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!(smpReady && !wrReq) && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic loadPtr(input logic [31:0] v);
    @(negedge clk); ptrLoad = 1; ptrLoadVal = v;
    @(negedge clk); ptrLoad = 0;
    check(wrAddr == v, "R10", "pointer load", wrAddr, v);
  endtask

  task automatic compareRec(input int off, input bit ts, input string req);
    int len = ts ? 38 : 29;
    for (int k = 0; k < len; k++)
      check(mem[off+k] === expByte(k, ts), req, $sformatf("byte %0d", k), mem[off+k], expByte(k, ts));
  endtask

  task automatic t_reset();
    check(wrAddr == 0, "R1", "ptr", wrAddr, 0);
    check(bufIrq == 0, "R1", "irq", bufIrq, 0);
    check(wrReq == 0, "R1", "wrReq", wrReq, 0);
    check(smpReady == 1, "R1", "smpReady", smpReady, 1);
  endtask

  task automatic t_plain();
    loadPtr(BASE);
    setFields(1); cfgTsEnable = 0;
    sendSample(); waitIdle();
    compareRec(0, 0, "R2");
    check(wrAddr == BASE + 29, "R5", "ptr after plain", wrAddr, BASE + 29);
    check(writes == 29, "R4", "byte transfers", writes, 29);
  endtask

  task automatic t_tsStall();
    setFields(2); cfgTsEnable = 1; stallMode = 1;
    sendSample(); waitIdle(); stallMode = 0;
    compareRec(29, 1, "R3");
    check(mem[29+37] == 8'h00, "R11", "end byte last", mem[66], 0);
    check(wrAddr == BASE + 67, "R5", "ptr after ts", wrAddr, BASE + 67);
  endtask

  task automatic t_loadIgnored();
    setFields(3); cfgTsEnable = 0; stallMode = 1;
    sendSample();
    repeat (6) @(negedge clk);
    ptrLoad = 1; ptrLoadVal = 32'h2000;
    @(negedge clk); ptrLoad = 0;
    waitIdle(); stallMode = 0;
    compareRec(67, 0, "R10");
    check(wrAddr == BASE + 96, "R10", "ptr ignores load mid-record", wrAddr, BASE + 96);
  endtask

  task automatic t_noFit();
    int w0 = writes;
    setFields(4); cfgTsEnable = 1;
    sendSample(); @(negedge clk);
    check(bufIrq == 1, "R7", "irq on overflow", bufIrq, 1);
    check(wrAddr == BASE + 96, "R7", "ptr unchanged", wrAddr, BASE + 96);
    check(writes == w0, "R7", "no write", writes, w0);
    check(mem[96] == 8'hEE, "R7", "sentinel", mem[96], 8'hEE);
    cfgTsEnable = 0; setFields(5);
    sendSample(); repeat (3) @(negedge clk);
    check(writes == w0, "R8", "dropped while full", writes, w0);
    check(bufIrq == 1, "R8", "irq held", bufIrq, 1);
    check(wrAddr == BASE + 96, "R8", "ptr held", wrAddr, BASE + 96);
  endtask

  task automatic t_clearExact();
    @(negedge clk); irqClear = 1;
    @(negedge clk); irqClear = 0;
    check(bufIrq == 0, "R9", "irq cleared", bufIrq, 0);
    cfgLimit = BASE + 96 + 29;
    setFields(6); cfgTsEnable = 0;
    sendSample(); waitIdle();
    compareRec(96, 0, "R6");
    check(wrAddr == cfgLimit, "R6", "exact fit ptr", wrAddr, cfgLimit);
    check(bufIrq == 0, "R6", "no irq on exact fit", bufIrq, 0);
    sendSample(); @(negedge clk);
    check(bufIrq == 1, "R7", "irq when zero space", bufIrq, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_tsStall();
    t_loadIgnored();
    t_noFit();
    t_clearExact();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule